// File: doc/BRIEF.md
# Character LCD Parallel Bus Sequencer

This block is the host-side master for a character display module on an 8-bit parallel bus. The bus has three control lines: register select, read/write and an enable strobe. After reset the block runs a fixed power-up list on its own. Once that list is finished it raises a ready output and takes requests through a valid/ready handshake. Each request carries a 2-bit kind and a byte. The kind says whether the byte is a command, display data, or a cursor address that the block turns into the address-setting command.

Before each write except the very first, the block asks the display whether it is still busy. It turns the data bus around to input, strobes status reads, and checks the top bit of each status word. It goes on to the write only when that bit reads clear. A build-time option swaps polling for fixed waits. With that option, every write is followed by a long or short pause chosen by the command just sent.

The strobe timing is set by parameters: setup clocks before enable rises, enable-high clocks, and hold clocks after enable falls.

Top module: `lcd_bus_seq`

## Requirements
- R1: While reset is held, lcd_en, lcd_rw, lcd_d_oe, req_ready and init_done are all 0.
- R2: The first strobe after reset is a write with lcd_rs=0 carrying FSET_CODE (default 0x38). No status read comes before it.
- R3: After the first write, the power-up list writes 0x0C, then 0x01, then 0x06, all with lcd_rs=0. init_done rises only after the fourth write and stays high. req_ready is never 1 while init_done is 0.
- R4: Request kinds are encoded as follows. Kind 2'b00 is a command: the byte goes out unchanged with lcd_rs=0. Kind 2'b01 is data: the byte goes out unchanged with lcd_rs=1. Any kind with bit 1 set is a cursor address: the byte goes out as {1'b1, byte[6:0]} with lcd_rs=0, so 0x43 becomes 0xC3. Requests are written in the order they were accepted, and req_kind and req_byte are ignored while req_valid is low.
- R5: With POLL_EN=1, every write after the first comes after status reads (lcd_rs=0, lcd_rw=1). A read that returns lcd_d_in[7]=1 is followed by another read. The write follows the first read that returns bit 7 = 0, and bits 6..0 of the status word have no effect.
- R6: Each enable pulse stays high for exactly EN_CLKS clocks. lcd_rs, lcd_rw, lcd_d_oe and lcd_d_out are steady for at least SETUP_CLKS clocks before enable rises.
- R7: lcd_d_oe is 0 for the whole of every status read. lcd_d_oe rises only after enable has been low for at least one full clock.
- R8: After a write strobe falls, lcd_d_oe, lcd_d_out and lcd_rs are held for at least HOLD_CLKS clocks.
- R9: With POLL_EN=0, no status read is issued and lcd_d_in is ignored. The gap from one write's enable fall to the next rise is at least LONG_WAIT_CLKS after a command byte below 0x04 and at least SHORT_WAIT_CLKS after any other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on a clock where both are high |
| req_kind | input | 2 | 00 command, 01 data, 1x cursor address |
| req_byte | input | 8 | Request payload |
| init_done | output | 1 | Power-up list finished |
| lcd_rs | output | 1 | Register select: 0 command/status, 1 data |
| lcd_rw | output | 1 | 1 = read from the display |
| lcd_en | output | 1 | Enable strobe |
| lcd_d_out | output | 8 | Bus value driven by the host |
| lcd_d_oe | output | 1 | Host drives the data bus when 1 |
| lcd_d_in | input | 8 | Bus value returned by the display |

## Verification
Enable rises SETUP_CLKS clocks after the control lines settle and falls EN_CLKS clocks later. Write data stays on the bus HOLD_CLKS clocks after that. The busy bit is taken on the last enable-high clock, so the bench changes lcd_d_in on the falling edge just after each status strobe rises. A request accepted on a clock edge reaches the bus only after an open-ended number of status reads. The bench therefore matches writes in order of enable rises and does not wait a fixed delay. All widths, gaps and read counts are counted on falling clock edges, away from the edge where the design changes.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_RD_SU,
      ST_RD_EN,
      ST_RD_HO,
      ST_WR_SU,
      ST_WR_EN,
      ST_WR_HO,
      ST_WAIT
   } seq_state_t;

   localparam logic [1:0] KIND_CMD  = 2'b00;
   localparam logic [1:0] KIND_DATA = 2'b01;
   localparam int         INIT_LEN  = 4;
   localparam int         BUS_W     = 8;

   // Byte placed on the bus for a request kind; address kinds force bit 7.
   function automatic logic [BUS_W-1:0] bus_byte(input logic [1:0] kind,
                                                 input logic [BUS_W-1:0] b);
      return kind[1] ? {1'b1, b[BUS_W-2:0]} : b;
   endfunction

   // Clear and home (command bytes 0x00..0x03) need the long pause.
   function automatic logic is_slow(input logic rs, input logic [BUS_W-1:0] b);
      return !rs && (b[BUS_W-1:2] == '0);
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic [TW-1:0] limit,
   output logic          last
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   assign last = (cnt == limit - 1'b1);
endmodule

// File: rtl/lcd_init_list.sv
module lcd_init_list
   import lcd_seq_pkg::*;
#(
   parameter logic [7:0] FSET_CODE  = 8'h38,
   parameter logic [7:0] DISP_CODE  = 8'h0C,
   parameter logic [7:0] CLR_CODE   = 8'h01,
   parameter logic [7:0] ENTRY_CODE = 8'h06,
   localparam int        IW         = $clog2(INIT_LEN)
) (
   input  logic [IW-1:0]    idx,
   output logic [BUS_W-1:0] code
);
   localparam logic [INIT_LEN*8-1:0] LIST = {ENTRY_CODE, CLR_CODE, DISP_CODE, FSET_CODE};

   logic [BUS_W-1:0] tbl [INIT_LEN];

   for (genvar i = 0; i < INIT_LEN; i++) begin : g_ent
      assign tbl[i] = LIST[i*8 +: 8];
   end

   assign code = tbl[idx];
endmodule

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
   import lcd_seq_pkg::*;
#(
   parameter bit         POLL_EN         = 1'b1,
   parameter int         EN_CLKS         = 4,
   parameter int         SETUP_CLKS      = 2,
   parameter int         HOLD_CLKS       = 2,
   parameter int         SHORT_WAIT_CLKS = 8000,
   parameter int         LONG_WAIT_CLKS  = 340000,
   parameter logic [7:0] FSET_CODE       = 8'h38
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_kind,
   input  logic [BUS_W-1:0] req_byte,
   output logic             init_done,
   output logic             lcd_rs,
   output logic             lcd_rw,
   output logic             lcd_en,
   output logic [BUS_W-1:0] lcd_d_out,
   output logic             lcd_d_oe,
   input  logic [BUS_W-1:0] lcd_d_in
);
   localparam int MAXL = imax(imax(LONG_WAIT_CLKS, SHORT_WAIT_CLKS),
                              imax(EN_CLKS, imax(SETUP_CLKS, HOLD_CLKS)));
   localparam int TW   = $clog2(MAXL + 1);
   localparam int IW   = $clog2(INIT_LEN);

   if (EN_CLKS < 1 || SETUP_CLKS < 1 || HOLD_CLKS < 1) begin : g_bad_phase
      $error("strobe phases need at least one clock each");
   end
   if (SHORT_WAIT_CLKS < 1 || LONG_WAIT_CLKS < SHORT_WAIT_CLKS) begin : g_bad_wait
      $error("long wait must not be shorter than short wait");
   end
   if (FSET_CODE[7:5] != 3'b001) begin : g_bad_fset
      $error("FSET_CODE is not a function-set command");
   end

   seq_state_t       state, nxt, start_st, post_wr_st;
   logic [TW-1:0]    limit;
   logic             last, advance, tmr_clear;
   logic [IW-1:0]    init_idx;
   logic [BUS_W-1:0] init_code, cur_byte;
   logic             first_done, busy_q, cur_rs, cur_slow, wr_ph;
   logic             din_unused;

   assign din_unused = ^lcd_d_in[BUS_W-2:0];

   // Variant: polled transfers start with a status read, timed ones pause after.
   if (POLL_EN) begin : g_poll
      assign start_st   = ST_RD_SU;
      assign post_wr_st = ST_FETCH;
   end else begin : g_wait
      assign start_st   = ST_WR_SU;
      assign post_wr_st = ST_WAIT;
   end

   lcd_init_list #(.FSET_CODE(FSET_CODE)) u_list (
      .idx  (init_idx),
      .code (init_code)
   );

   lcd_phase_timer #(.TW(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tmr_clear),
      .limit (limit),
      .last  (last)
   );

   assign cur_slow = is_slow(cur_rs, cur_byte);

   always_comb begin
      case (state)
         ST_RD_SU, ST_WR_SU: limit = TW'(SETUP_CLKS);
         ST_RD_EN, ST_WR_EN: limit = TW'(EN_CLKS);
         ST_RD_HO, ST_WR_HO: limit = TW'(HOLD_CLKS);
         ST_WAIT:            limit = cur_slow ? TW'(LONG_WAIT_CLKS) : TW'(SHORT_WAIT_CLKS);
         default:            limit = TW'(1);
      endcase
   end

   always_comb begin
      nxt = state;
      case (state)
         ST_FETCH: begin
            if (!init_done)     nxt = first_done ? start_st : ST_WR_SU;
            else if (req_valid) nxt = start_st;
         end
         ST_RD_SU: if (last) nxt = ST_RD_EN;
         ST_RD_EN: if (last) nxt = ST_RD_HO;
         ST_RD_HO: if (last) nxt = busy_q ? ST_RD_SU : ST_WR_SU;
         ST_WR_SU: if (last) nxt = ST_WR_EN;
         ST_WR_EN: if (last) nxt = ST_WR_HO;
         ST_WR_HO: if (last) nxt = post_wr_st;
         ST_WAIT:  if (last) nxt = ST_FETCH;
         default:            nxt = ST_FETCH;
      endcase
   end

   assign advance   = (nxt != state);
   assign tmr_clear = advance || (state == ST_FETCH);
   assign req_ready = (state == ST_FETCH) && init_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_FETCH;
         init_idx   <= '0;
         init_done  <= 1'b0;
         first_done <= 1'b0;
         busy_q     <= 1'b0;
         cur_rs     <= 1'b0;
         cur_byte   <= '0;
      end else begin
         state <= nxt;
         if (state == ST_FETCH && advance) begin
            if (!init_done) begin
               cur_rs   <= 1'b0;
               cur_byte <= init_code;
            end else begin
               cur_rs   <= (req_kind == KIND_DATA);
               cur_byte <= bus_byte(req_kind, req_byte);
            end
         end
         if (state == ST_RD_EN && last) busy_q <= lcd_d_in[BUS_W-1];
         if (state == ST_WR_HO && last) begin
            first_done <= 1'b1;
            if (!init_done) begin
               if (init_idx == IW'(INIT_LEN - 1)) init_done <= 1'b1;
               else                               init_idx  <= init_idx + 1'b1;
            end
         end
      end
   end

   assign wr_ph     = (state == ST_WR_SU) || (state == ST_WR_EN) || (state == ST_WR_HO);
   assign lcd_rw    = (state == ST_RD_SU) || (state == ST_RD_EN) || (state == ST_RD_HO);
   assign lcd_en    = (state == ST_RD_EN) || (state == ST_WR_EN);
   assign lcd_rs    = wr_ph && cur_rs;
   assign lcd_d_oe  = wr_ph;
   assign lcd_d_out = cur_byte;
endmodule

// File: rtl/lcd_bus_seq_chk.sv
module lcd_bus_seq_chk #(
   parameter bit POLL_EN = 1'b1,
   parameter int EN_CLKS = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       lcd_en,
   input logic       lcd_rs,
   input logic       lcd_rw,
   input logic       lcd_d_oe,
   input logic [7:0] lcd_d_out,
   input logic       req_ready,
   input logic       init_done
);
   logic [15:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_cnt <= '0;
      else if (lcd_en) hi_cnt <= hi_cnt + 1'b1;
      else             hi_cnt <= '0;
   end

   assert_en_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_en) |-> hi_cnt == 16'(EN_CLKS));

   assert_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_en) |-> $stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_oe));

   assert_no_drive_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_rw |-> !lcd_d_oe);

   assert_oe_after_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_d_oe) |-> !lcd_en && !$past(lcd_en));

   assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_en) && $past(lcd_d_oe) |-> lcd_d_oe && $stable(lcd_d_out) && $stable(lcd_rs));

   assert_ready_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> init_done);

   assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   if (!POLL_EN) begin : g_timed
      assert_no_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !lcd_rw);
   end
endmodule

bind lcd_bus_seq lcd_bus_seq_chk #(.POLL_EN(POLL_EN), .EN_CLKS(EN_CLKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lcd_en    (lcd_en),
   .lcd_rs    (lcd_rs),
   .lcd_rw    (lcd_rw),
   .lcd_d_oe  (lcd_d_oe),
   .lcd_d_out (lcd_d_out),
   .req_ready (req_ready),
   .init_done (init_done)
);

// File: tb/sim_lcd_bus_seq.sv
`timescale 1ns/1ps
module sim_lcd_bus_seq;
   localparam int EN_C = 3, SU_C = 2, HO_C = 2, SW_C = 20, LW_C = 60;
   localparam int NREQ = 40, WD = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       r_valid = 1'b0;
   logic [1:0] r_kind = 2'b00;
   logic [7:0] r_byte = 8'h00;
   logic       ready0, done0, rs0, rw0, en0, oe0;
   logic [7:0] dout0;
   logic [7:0] din0 = 8'h00;
   logic       ready1, done1, rs1, rw1, en1, oe1;
   logic [7:0] dout1;

   lcd_bus_seq #(.POLL_EN(1'b1), .EN_CLKS(EN_C), .SETUP_CLKS(SU_C), .HOLD_CLKS(HO_C),
                 .SHORT_WAIT_CLKS(SW_C), .LONG_WAIT_CLKS(LW_C)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(r_valid), .req_ready(ready0),
      .req_kind(r_kind), .req_byte(r_byte), .init_done(done0),
      .lcd_rs(rs0), .lcd_rw(rw0), .lcd_en(en0), .lcd_d_out(dout0),
      .lcd_d_oe(oe0), .lcd_d_in(din0));

   lcd_bus_seq #(.POLL_EN(1'b0), .EN_CLKS(EN_C), .SETUP_CLKS(SU_C), .HOLD_CLKS(HO_C),
                 .SHORT_WAIT_CLKS(SW_C), .LONG_WAIT_CLKS(LW_C)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_ready(ready1),
      .req_kind(2'b00), .req_byte(8'h00), .init_done(done1),
      .lcd_rs(rs1), .lcd_rw(rw1), .lcd_en(en1), .lcd_d_out(dout1),
      .lcd_d_oe(oe1), .lcd_d_in(8'hFF));

   int total = 0, bad = 0, cyc = 0;
   logic [7:0] exp_b [64];
   logic       exp_rs [64];
   int         busy_plan [64];
   int         exp_n = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] want_byte(input logic [1:0] k, input logic [7:0] b);
      return k[1] ? (b | 8'h80) : b;
   endfunction

   // ---------------- monitor for the polled instance ----------------
   logic        p_en = 0, p_oe = 0, in_hold = 0, hold_rs = 0;
   logic [10:0] p_ctl = '0;
   logic [7:0]  hold_b = '0;
   int          stab = 0, hi = 0, hold_c = 0, reads_since = 0, wr_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ready0 && !done0) chk(0, "R3 ready before init done", ready0, 0);
         if (oe0 && !p_oe && (en0 || p_en)) chk(0, "R7 drive while enable high", 1, 0);
         if ({rs0, rw0, oe0, dout0} != p_ctl) stab = 0; else stab++;
         if (en0 && !p_en) begin
            chk(stab >= SU_C, "R6 setup clocks", stab, SU_C);
            if (rw0) begin
               chk(!oe0 && !rs0, "R7 status read bus released", {oe0, rs0}, 0);
               din0 = {(reads_since < busy_plan[wr_seen]), 7'($urandom)};
               reads_since++;
            end else begin
               if (wr_seen == 0)
                  chk(reads_since == 0, "R2 no read before function set", reads_since, 0);
               else
                  chk(reads_since == busy_plan[wr_seen] + 1, "R5 status reads before write",
                      reads_since, busy_plan[wr_seen] + 1);
               if (wr_seen < exp_n)
                  chk(dout0 == exp_b[wr_seen] && rs0 == exp_rs[wr_seen],
                      (wr_seen == 0) ? "R2 first write" : (wr_seen < 4) ? "R3 init write" : "R4 request write",
                      {rs0, dout0}, {exp_rs[wr_seen], exp_b[wr_seen]});
               else
                  chk(0, "R4 unexpected write", dout0, 0);
               if (wr_seen < 4) chk(!done0, "R3 init_done early", done0, 0);
               wr_seen++;
               reads_since = 0;
            end
         end
         if (en0) hi++;
         else if (p_en) begin
            chk(hi == EN_C, "R6 enable width", hi, EN_C);
            hi = 0;
            if (!rw0) begin in_hold = 1; hold_c = 0; hold_b = dout0; hold_rs = rs0; end
         end
         if (in_hold) begin
            if (oe0 && !en0 && dout0 == hold_b && rs0 == hold_rs) hold_c++;
            else begin
               chk(hold_c >= HO_C, "R8 write hold", hold_c, HO_C);
               in_hold = 0;
            end
         end
      end
      p_en  = en0;
      p_oe  = oe0;
      p_ctl = {rs0, rw0, oe0, dout0};
   end

   // ---------------- monitor for the timed instance ----------------
   logic p_en1 = 0;
   int   gap1 = 0, need1 = 0, wr1 = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (en1 && !p_en1) begin
            chk(!rw1, "R9 no status read in timed mode", rw1, 0);
            if (wr1 > 0) chk(gap1 >= need1, "R9 pause after write", gap1, need1);
            if (wr1 < 4) chk(dout1 == exp_b[wr1] && !rs1, "R9 timed init write", {rs1, dout1}, exp_b[wr1]);
            wr1++;
            gap1 = 0;
         end else if (!en1) gap1++;
         if (!en1 && p_en1) need1 = (!rs1 && dout1 < 8'h04) ? LW_C : SW_C;
      end
      p_en1 = en1;
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > WD) begin
         total++;
         bad++;
         $display("FAIL watchdog R4 actual=%0d expected<%0d", cyc, WD);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic send(input logic [1:0] k, input logic [7:0] b);
      r_valid = 1'b1;
      r_kind  = k;
      r_byte  = b;
      while (!ready0) @(negedge clk);
      exp_b[exp_n]  = want_byte(k, b);
      exp_rs[exp_n] = (k == 2'b01);
      exp_n++;
      @(negedge clk);
      r_valid = 1'b0;
      r_kind  = 2'($urandom);
      r_byte  = 8'($urandom);
      chk(!ready0, "R4 ready drops after accept", ready0, 0);
      repeat ($urandom % 3) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd4242));
      exp_b[0] = 8'h38; exp_b[1] = 8'h0C; exp_b[2] = 8'h01; exp_b[3] = 8'h06;
      for (int i = 0; i < 4; i++) exp_rs[i] = 1'b0;
      exp_n = 4;
      for (int i = 0; i < 64; i++) busy_plan[i] = int'($urandom % 4);
      busy_plan[1] = 0;
      busy_plan[5] = 6;

      repeat (3) @(negedge clk);
      chk(!en0 && !oe0 && !rw0 && !ready0 && !done0, "R1 reset state u0",
          {en0, oe0, rw0, ready0, done0}, 0);
      chk(!en1 && !oe1 && !rw1 && !ready1 && !done1, "R1 reset state u1",
          {en1, oe1, rw1, ready1, done1}, 0);
      rst_n = 1'b1;

      send(2'b10, 8'h43);   // R4: address 0x43 -> 0xC3
      send(2'b11, 8'h7F);   // R4: address with kind 11 -> 0xFF
      send(2'b01, 8'hFF);   // R4: data, rs=1
      send(2'b00, 8'h01);   // R4: raw command
      send(2'b01, 8'h20);
      chk(done0, "R3 init_done held", done0, 1);
      for (int n = 5; n < NREQ; n++) send(2'($urandom), 8'($urandom));

      while (wr_seen < exp_n) @(negedge clk);
      repeat (20) @(negedge clk);
      while (wr1 < 4 || !done1) @(negedge clk);
      repeat (LW_C) @(negedge clk);
      chk(wr_seen == exp_n, "R4 all requests written", wr_seen, exp_n);
      chk(done0 && !en0, "R3 init_done stays high", {done0, en0}, 2'b10);
      chk(wr1 == 4 && done1, "R9 timed instance ran only the init list", wr1, 4);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule